// File: doc/BRIEF.md
# Operand Address Register Chaining Unit

This block holds the two operand address registers and the one-character variant register of a two-operand character machine. At extraction time it loads them from a decoded instruction. An instruction may carry both operand addresses, only the first, or neither. When the first address is the only one given, a per-opcode flag picks one of two behaviours. The block can copy the whole first register into the second ("duplicate first"). Or it can leave the second register alone, so the second operand is implied ("keep second").

When an operation on the fields completes, each register steps down by the number of characters it walked. The step wraps at the register width. After that, both registers point just below their fields, and the next instruction can leave out its addresses and reuse them (chaining).

An address-size mode selects how many low bits an explicit address writes:
- two-character mode writes the low 12 bits;
- three-character mode writes the low 15 bits;
- four-character mode writes all bits.

In the two shorter modes the upper bank/sector bits are left as they were. The only path that changes those upper bits is the duplicate copy.

Top module: `addr_chain_unit`

## Requirements
- R1: A synchronous reset clears the first register, the second register and the variant register to zero.
- R2: On an extract strobe with format 0 (both addresses), the first address loads the first register and the second address loads the second register. Both values appear one cycle later.
- R3: On an extract strobe with format 1 (first address only) and the duplicate flag set, the second register receives every bit of the newly loaded first register. This includes the upper bits that explicit loads keep in the shorter modes.
- R4: On an extract strobe with format 1 and the duplicate flag clear, only the first register loads, and the second register keeps its value.
- R5: On an extract strobe with format 2 or 3 (no addresses), both address registers keep their values.
- R6: The variant register loads the variant character only on an extract strobe that has the variant-present flag set. In every other cycle it keeps its value.
- R7: On a done strobe, the first register decreases by the first field length and the second register decreases by the second field length, each modulo 2^ADDR_W.
- R8: Mode 0 (two-character) writes the low 12 bits of an explicit address, mode 1 (three-character) writes the low 15 bits, and modes 2 and 3 (four-character) write all bits. Bits that are not written keep their old values.
- R9: When the extract strobe and the done strobe are high in the same cycle, the extract takes effect and the done is ignored.
- R10: Chained instructions give the same register sequence as explicit coding. Starting from 900/700 with 10-character fields, the registers read 890/690, then 880/680, then 870/670.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extStb | input | 1 | Extract strobe, one cycle per instruction |
| fmt | input | 2 | Format: 0 both addresses, 1 first address only, 2/3 none |
| dupA | input | 1 | For format 1: 1 = duplicate first, 0 = keep second |
| hasVar | input | 1 | Instruction carries a variant character |
| addrMode | input | 2 | Address size: 0 two-char, 1 three-char, 2/3 four-char |
| aAddr | input | ADDR_W | First operand address from the instruction |
| bAddr | input | ADDR_W | Second operand address from the instruction |
| varChar | input | CHAR_W | Variant character |
| doneStb | input | 1 | Field operation complete |
| aLen | input | LEN_W | Characters walked in the first field |
| bLen | input | LEN_W | Characters walked in the second field |
| aarOut | output | ADDR_W | First address register |
| barOut | output | ADDR_W | Second address register |
| varOut | output | CHAR_W | Variant register |

## Verification
The three-instruction sequence runs from 900/700 once with explicit addresses and then with chained, address-free extracts. The 890/690, 880/680, 870/670 sequence tells chaining apart from reloading.

An A-only extract is run with each setting of the duplicate flag. Comparing the second register afterwards separates the duplicate copy from the preserve behaviour. Loads in each address mode, on top of a register whose upper bits are all set, show which bits each mode writes. A later duplicate shows those upper bits being copied.

A decrement below zero exercises the wrap, and coincident strobes exercise the priority rule.

// File: rtl/addr_chain_pkg.sv
package addr_chain_pkg;
  localparam int SHORT2_W = 12;
  localparam int SHORT3_W = 15;

  typedef enum logic [1:0] {
    FMT_BOTH  = 2'd0,
    FMT_AONLY = 2'd1,
    FMT_NONE  = 2'd2,
    FMT_NONE2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic ldAar;
    logic ldBarExpl;
    logic ldBarDup;
    logic ldVar;
    logic walk;
  } ctrl_t;
endpackage

// File: rtl/addr_chain_ctrl.sv
module addr_chain_ctrl
  import addr_chain_pkg::*;
(
  input  logic       extStb,
  input  logic [1:0] fmt,
  input  logic       dupA,
  input  logic       hasVar,
  input  logic       doneStb,
  output ctrl_t      ctrl
);
  fmt_e fmtE;

  always_comb begin
    fmtE = fmt_e'(fmt);
    ctrl = '0;
    if (extStb) begin
      ctrl.ldVar = hasVar;
      unique case (fmtE)
        FMT_BOTH: begin
          ctrl.ldAar     = 1'b1;
          ctrl.ldBarExpl = 1'b1;
        end
        FMT_AONLY: begin
          ctrl.ldAar    = 1'b1;
          ctrl.ldBarDup = dupA;
        end
        default: ;
      endcase
    end else begin
      ctrl.walk = doneStb;
    end
  end
endmodule

// File: rtl/addr_chain_dp.sv
module addr_chain_dp
  import addr_chain_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CHAR_W = 6,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [1:0]        addrMode,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [CHAR_W-1:0] varChar,
  input  logic [LEN_W-1:0]  aLen,
  input  logic [LEN_W-1:0]  bLen,
  output logic [ADDR_W-1:0] aarQ,
  output logic [ADDR_W-1:0] barQ,
  output logic [CHAR_W-1:0] varQ
);
  localparam logic [ADDR_W-1:0] MASK2 = ADDR_W'((64'd1 << SHORT2_W) - 64'd1);
  localparam logic [ADDR_W-1:0] MASK3 = ADDR_W'((64'd1 << SHORT3_W) - 64'd1);

  logic [ADDR_W-1:0] loadMask;
  logic [ADDR_W-1:0] aarMerged;
  logic [ADDR_W-1:0] barMerged;

  always_comb begin
    unique case (addrMode)
      2'd0:    loadMask = MASK2;
      2'd1:    loadMask = MASK3;
      default: loadMask = '1;
    endcase
    aarMerged = (aarQ & ~loadMask) | (aAddr & loadMask);
    barMerged = (barQ & ~loadMask) | (bAddr & loadMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aarQ <= '0;
      barQ <= '0;
      varQ <= '0;
    end else begin
      if (ctrl.ldAar)          aarQ <= aarMerged;
      else if (ctrl.walk)      aarQ <= aarQ - ADDR_W'(aLen);

      if (ctrl.ldBarDup)       barQ <= aarMerged;
      else if (ctrl.ldBarExpl) barQ <= barMerged;
      else if (ctrl.walk)      barQ <= barQ - ADDR_W'(bLen);

      if (ctrl.ldVar)          varQ <= varChar;
    end
  end
endmodule

// File: rtl/addr_chain_unit.sv
module addr_chain_unit
  import addr_chain_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CHAR_W = 6,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extStb,
  input  logic [1:0]        fmt,
  input  logic              dupA,
  input  logic              hasVar,
  input  logic [1:0]        addrMode,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [CHAR_W-1:0] varChar,
  input  logic              doneStb,
  input  logic [LEN_W-1:0]  aLen,
  input  logic [LEN_W-1:0]  bLen,
  output logic [ADDR_W-1:0] aarOut,
  output logic [ADDR_W-1:0] barOut,
  output logic [CHAR_W-1:0] varOut
);
  ctrl_t ctrl;

  addr_chain_ctrl uCtrl (
    .extStb(extStb), .fmt(fmt), .dupA(dupA), .hasVar(hasVar),
    .doneStb(doneStb), .ctrl(ctrl)
  );

  addr_chain_dp #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .addrMode(addrMode),
    .aAddr(aAddr), .bAddr(bAddr), .varChar(varChar),
    .aLen(aLen), .bLen(bLen),
    .aarQ(aarOut), .barQ(barOut), .varQ(varOut)
  );
endmodule

// File: rtl/addr_chain_checker.sv
module addr_chain_checker #(
  parameter int ADDR_W = 18,
  parameter int CHAR_W = 6,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              extStb,
  input logic [1:0]        fmt,
  input logic              dupA,
  input logic              hasVar,
  input logic              doneStb,
  input logic [LEN_W-1:0]  aLen,
  input logic [LEN_W-1:0]  bLen,
  input logic [ADDR_W-1:0] aarOut,
  input logic [ADDR_W-1:0] barOut,
  input logic [CHAR_W-1:0] varOut
);
  // R3: duplicate copy makes both registers equal
  a_r3_dup_copy: assert property (@(posedge clk) disable iff (rst)
    (extStb && fmt == 2'd1 && dupA) |=> (barOut == aarOut));

  // R4: preserve keeps second register
  a_r4_keep_b: assert property (@(posedge clk) disable iff (rst)
    (extStb && fmt == 2'd1 && !dupA) |=> (barOut == $past(barOut)));

  // R5: no-address extract holds both registers
  a_r5_hold_both: assert property (@(posedge clk) disable iff (rst)
    (extStb && fmt[1]) |=> (aarOut == $past(aarOut) && barOut == $past(barOut)));

  // R6: variant unchanged unless loaded
  a_r6_var_keep: assert property (@(posedge clk) disable iff (rst)
    !(extStb && hasVar) |=> (varOut == $past(varOut)));

  // R7: walk decrements with wrap
  a_r7_walk: assert property (@(posedge clk) disable iff (rst)
    (!extStb && doneStb) |=>
      (aarOut == ADDR_W'($past(aarOut) - ADDR_W'($past(aLen))) &&
       barOut == ADDR_W'($past(barOut) - ADDR_W'($past(bLen)))));
endmodule

bind addr_chain_unit addr_chain_checker #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rst(rst), .extStb(extStb), .fmt(fmt), .dupA(dupA), .hasVar(hasVar),
  .doneStb(doneStb), .aLen(aLen), .bLen(bLen),
  .aarOut(aarOut), .barOut(barOut), .varOut(varOut)
);

// File: tb/addr_chain_unit_test.sv
module addr_chain_unit_test;
  localparam int ADDR_W = 18;
  localparam int CHAR_W = 6;
  localparam int LEN_W  = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extStb = 1'b0, dupA = 1'b0, hasVar = 1'b0, doneStb = 1'b0;
  logic [1:0] fmt = 2'd0, addrMode = 2'd2;
  logic [ADDR_W-1:0] aAddr = '0, bAddr = '0;
  logic [CHAR_W-1:0] varChar = '0;
  logic [LEN_W-1:0] aLen = '0, bLen = '0;
  logic [ADDR_W-1:0] aarOut, barOut;
  logic [CHAR_W-1:0] varOut;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] expA, expB;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_chain_unit #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .extStb(extStb), .fmt(fmt), .dupA(dupA), .hasVar(hasVar),
    .addrMode(addrMode), .aAddr(aAddr), .bAddr(bAddr), .varChar(varChar),
    .doneStb(doneStb), .aLen(aLen), .bLen(bLen),
    .aarOut(aarOut), .barOut(barOut), .varOut(varOut)
  );

  function automatic logic [ADDR_W-1:0] merge(input logic [ADDR_W-1:0] old,
                                               input logic [ADDR_W-1:0] nw, input int bits);
    logic [ADDR_W-1:0] m;
    m = (bits >= ADDR_W) ? '1 : ADDR_W'((64'd1 << bits) - 64'd1);
    return (old & ~m) | (nw & m);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample at following negedge
  task automatic step(input logic ext, input logic [1:0] f, input logic dup, input logic hv,
                      input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                      input logic [CHAR_W-1:0] v, input logic done,
                      input logic [LEN_W-1:0] la, input logic [LEN_W-1:0] lb);
    extStb = ext; fmt = f; dupA = dup; hasVar = hv; aAddr = a; bAddr = b;
    varChar = v; doneStb = done; aLen = la; bLen = lb;
    @(negedge clk);
    extStb = 1'b0; doneStb = 1'b0; hasVar = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 aar", aarOut, 0);
    chk("R1 bar", barOut, 0);
    chk("R1 var", varOut, 0);
  endtask

  task automatic t_explicit();
    addrMode = 2'd2;
    step(1, 2'd0, 0, 1, 900, 700, 6'd5, 0, 0, 0);
    chk("R2 aar", aarOut, 900);
    chk("R2 bar", barOut, 700);
    chk("R6 var load", varOut, 5);
    step(0, 2'd0, 0, 0, 0, 0, 0, 1, 10, 10);
    chk("R7 aar walk", aarOut, 890);
    chk("R7 bar walk", barOut, 690);
  endtask

  task automatic t_chain();
    step(1, 2'd2, 0, 0, 11, 22, 6'd9, 0, 0, 0);
    chk("R5 aar hold", aarOut, 890);
    chk("R5 bar hold", barOut, 690);
    chk("R6 var keep", varOut, 5);
    step(0, 2'd0, 0, 0, 0, 0, 0, 1, 10, 10);
    chk("R10 aar 2nd", aarOut, 880);
    chk("R10 bar 2nd", barOut, 680);
    step(1, 2'd3, 1, 0, 33, 44, 0, 0, 0, 0);
    chk("R5 fmt3 hold", barOut, 680);
    step(0, 2'd0, 0, 0, 0, 0, 0, 1, 10, 10);
    chk("R10 aar 3rd", aarOut, 870);
    chk("R10 bar 3rd", barOut, 670);
  endtask

  task automatic t_dup_keep();
    step(1, 2'd1, 1, 0, 1234, 77, 0, 0, 0, 0);
    chk("R3 aar", aarOut, 1234);
    chk("R3 bar dup", barOut, 1234);
    step(1, 2'd1, 0, 0, 50, 77, 0, 0, 0, 0);
    chk("R4 aar", aarOut, 50);
    chk("R4 bar keep", barOut, 1234);
  endtask

  task automatic t_wrap();
    step(0, 2'd0, 0, 0, 0, 0, 0, 1, 60, 0);
    chk("R7 wrap aar", aarOut, (1 << ADDR_W) - 10);
    chk("R7 zero len bar", barOut, 1234);
  endtask

  task automatic t_modes();
    expA = merge(aarOut, 18'h00123, 12);
    expB = merge(barOut, 18'h3F456, 12);
    addrMode = 2'd0;
    step(1, 2'd0, 0, 0, 18'h00123, 18'h3F456, 0, 0, 0, 0);
    chk("R8 mode0 aar", aarOut, expA);
    chk("R8 mode0 bar", barOut, expB);
    expA = merge(aarOut, 18'h01ABC, 15);
    addrMode = 2'd1;
    step(1, 2'd1, 0, 0, 18'h01ABC, 0, 0, 0, 0, 0);
    chk("R8 mode1 aar", aarOut, expA);
    expA = merge(aarOut, 18'h00007, 12);
    addrMode = 2'd0;
    step(1, 2'd1, 1, 0, 18'h00007, 0, 0, 0, 0, 0);
    chk("R3 upper bits aar", aarOut, expA);
    chk("R3 upper bits bar", barOut, expA);
    addrMode = 2'd2;
  endtask

  task automatic t_prio();
    step(1, 2'd0, 0, 1, 100, 200, 6'd33, 1, 5, 5);
    chk("R9 aar", aarOut, 100);
    chk("R9 bar", barOut, 200);
    chk("R6 var", varOut, 33);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_explicit();
    t_chain();
    t_dup_keep();
    t_wrap();
    t_modes();
    t_prio();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule